// File: doc/BRIEF.md
# Change-of-Flow Trace Recorder

This block sits beside a small 8-bit CPU core and watches the instructions it retires. Each retired instruction arrives as a one-cycle strobe with a class code, the address of its opcode, the address the core continues at, and a flag telling whether a conditional branch went its way. Sequential instructions and jumps whose target is fixed in the object code are dropped. Only events that break the straight-line flow are kept, and each one becomes a single 16-bit address in a small on-chip FIFO. A debugger that holds the program image can rebuild the full execution path from those addresses.

The address that is kept depends on the event. A taken conditional branch stores its own opcode address, since the target follows from the code. A jump or call through the index register pair, an interrupt entry, or a return stores the destination, because that is known only at run time. When the FIFO is full, a new record replaces the oldest one and raises a sticky overflow flag. The flag clears when the debugger signals that it has read the fill count. An arm input turns capture on and off.

Top module: `cof_trace`

## Requirements
- R1: A retirement of class 0 (sequential) or class 4 (jump or call to a fixed target) writes no record, whatever the taken flag is.
- R2: A retirement of class 1 (conditional branch) with the taken flag high writes one record holding the opcode address.
- R3: A retirement of class 1 with the taken flag low writes no record.
- R4: A retirement of class 2 (branch-always) or class 3 (branch-never) writes no record, whatever the taken flag is.
- R5: A retirement of class 5 (jump or call through the index pair) writes one record holding the destination address.
- R6: A retirement of class 6 (interrupt entry) or class 7 (return from interrupt or from subroutine) writes one record holding the destination address.
- R7: Records leave in write order. `rd_data` always shows the oldest record. A one-cycle `rd_en` pulse removes it. `fill` gives the number held, from 0 to 8, and is updated one cycle after a write or a removal.
- R8: A record written while 8 are held, with no removal in the same cycle, replaces the oldest record, leaves `fill` at 8, and sets `overflow`. `overflow` then stays high through later reads.
- R9: A `fill_seen` pulse clears `overflow` on the next cycle. If an overflowing write happens in the same cycle, the set wins.
- R10: While `arm` is low, retirements write nothing. Held records and `rd_data` stay unchanged unless `rd_en` removes one.
- R11: While `rst` is high at a clock edge, the FIFO is emptied and `overflow` is cleared.
- R12: `rd_en` with an empty FIFO has no effect. A write together with `rd_en` while 8 are held leaves `fill` at 8 and does not set `overflow`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Capture enable |
| retire | input | 1 | One-cycle strobe for a retired instruction |
| iclass | input | 3 | Instruction class code (see R1 to R6) |
| op_addr | input | 16 | Address of the retired opcode |
| dest_addr | input | 16 | Address execution continues at |
| taken | input | 1 | Conditional branch condition was true |
| rd_en | input | 1 | Remove the oldest record |
| fill_seen | input | 1 | Debugger has read the fill count; clears overflow |
| rd_data | output | 16 | Oldest held record |
| fill | output | 4 | Number of records held |
| overflow | output | 1 | Sticky flag: a record was lost |

## Verification
The properties assume that `retire` is a single-cycle pulse, with the class, addresses and taken flag valid in that cycle. Several of them also assume that `rd_en` is low when a single event is being checked for its effect on the fill count. The stimulus holds to this. Every event is driven for exactly one cycle and then returned to idle. Removals happen in cycles of their own, except in the directed case that tests a write and a removal together. Because all inputs change on the falling edge, each property sees stable values at the rising edge.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

    localparam int ADDR_W = 16;
    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        EV_SEQ      = 3'd0,
        EV_BCOND    = 3'd1,
        EV_ALWAYS   = 3'd2,
        EV_NEVER    = 3'd3,
        EV_DIRECT   = 3'd4,
        EV_INDIRECT = 3'd5,
        EV_IRQ      = 3'd6,
        EV_RETURN   = 3'd7
    } ev_class_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
    } cof_rec_t;

    // Decide whether an event is recorded and which address it keeps.
    function automatic cof_rec_t pick_record(
        input ev_class_e         cls,
        input logic              tk,
        input logic [ADDR_W-1:0] src,
        input logic [ADDR_W-1:0] dst
    );
        cof_rec_t r;
        r.hit  = 1'b0;
        r.addr = dst;
        unique case (cls)
            EV_BCOND: begin
                r.hit  = tk;
                r.addr = src;
            end
            EV_INDIRECT, EV_IRQ, EV_RETURN: r.hit = 1'b1;
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cof_classify.sv
module cof_classify
    import cof_trace_pkg::*;
(
    input  logic                 armed,
    input  logic                 retire,
    input  logic [CLASS_W-1:0]   iclass,
    input  logic [ADDR_W-1:0]    op_addr,
    input  logic [ADDR_W-1:0]    dest_addr,
    input  logic                 taken,
    output logic                 push,
    output logic [ADDR_W-1:0]    push_addr
);
    cof_rec_t rec;

    always_comb begin
        rec       = pick_record(ev_class_e'(iclass), taken, op_addr, dest_addr);
        push      = armed && retire && rec.hit;
        push_addr = rec.addr;
    end
endmodule

// File: rtl/cof_fifo.sv
module cof_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop_req,
    input  logic             clr_ovf,
    output logic [DW-1:0]    rdata,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, pop, overwrite;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == FULL_CNT);
    assign pop       = pop_req && (count != '0);
    assign overwrite = push && full && !pop;
    assign rdata     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push)
                wr_ptr <= adv(wr_ptr);
            if (pop || overwrite)
                rd_ptr <= adv(rd_ptr);
            if (push && !pop && !full)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
            if (overwrite)
                overflow <= 1'b1;
            else if (clr_ovf)
                overflow <= 1'b0;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g))
                mem[g] <= wdata;
        end
    end
endmodule

// File: rtl/cof_trace.sv
module cof_trace
    import cof_trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                retire,
    input  logic [2:0]          iclass,
    input  logic [15:0]         op_addr,
    input  logic [15:0]         dest_addr,
    input  logic                taken,
    input  logic                rd_en,
    input  logic                fill_seen,
    output logic [15:0]         rd_data,
    output logic [CNT_W-1:0]    fill,
    output logic                overflow
);
    logic              push;
    logic [ADDR_W-1:0] push_addr;

    cof_classify u_classify (
        .armed     (arm),
        .retire    (retire),
        .iclass    (iclass),
        .op_addr   (op_addr),
        .dest_addr (dest_addr),
        .taken     (taken),
        .push      (push),
        .push_addr (push_addr)
    );

    cof_fifo #(.DW(ADDR_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wdata    (push_addr),
        .pop_req  (rd_en),
        .clr_ovf  (fill_seen),
        .rdata    (rd_data),
        .count    (fill),
        .overflow (overflow)
    );
endmodule

// File: rtl/cof_trace_chk.sv
module cof_trace_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic             retire,
    input logic [2:0]       iclass,
    input logic [15:0]      op_addr,
    input logic [15:0]      dest_addr,
    input logic             taken,
    input logic             rd_en,
    input logic             fill_seen,
    input logic [15:0]      rd_data,
    input logic [CNT_W-1:0] fill,
    input logic             overflow
);
    logic keeps;
    assign keeps = retire && arm &&
        ((iclass == 3'd1 && taken) || iclass >= 3'd5);

    // R1
    a_r1_quiet_class: assert property (@(posedge clk) disable iff (rst)
        (retire && (iclass == 3'd0 || iclass == 3'd4) && !rd_en)
        |=> fill == $past(fill));

    a_r3_not_taken_quiet: assert property (@(posedge clk) disable iff (rst)
        (retire && iclass == 3'd1 && !taken && !rd_en)
        |=> fill == $past(fill));

    a_r4_uncond_quiet: assert property (@(posedge clk) disable iff (rst)
        (retire && (iclass == 3'd2 || iclass == 3'd3) && !rd_en)
        |=> fill == $past(fill));

    a_r2_source_kept: assert property (@(posedge clk) disable iff (rst)
        (retire && arm && iclass == 3'd1 && taken && fill == '0 && !rd_en)
        |=> (fill == CNT_W'(1) && rd_data == $past(op_addr)));

    a_r5_r6_dest_kept: assert property (@(posedge clk) disable iff (rst)
        (retire && arm && iclass >= 3'd5 && fill == '0 && !rd_en)
        |=> (fill == CNT_W'(1) && rd_data == $past(dest_addr)));

    a_r7_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    a_r8_overflow_set: assert property (@(posedge clk) disable iff (rst)
        (keeps && fill == CNT_W'(DEPTH) && !rd_en)
        |=> (overflow && fill == CNT_W'(DEPTH)));

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (fill_seen && !retire) |=> !overflow);

    a_r10_disarmed_hold: assert property (@(posedge clk) disable iff (rst)
        (!arm && !rd_en) |=> ($stable(fill) && $stable(rd_data)));

    a_r11_reset: assert property (@(posedge clk)
        rst |=> (fill == '0 && !overflow));

    a_r12_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fill == '0 && !keeps) |=> fill == '0);
endmodule

bind cof_trace cof_trace_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .arm(arm), .retire(retire), .iclass(iclass),
    .op_addr(op_addr), .dest_addr(dest_addr), .taken(taken),
    .rd_en(rd_en), .fill_seen(fill_seen), .rd_data(rd_data),
    .fill(fill), .overflow(overflow)
);

// File: tb/cof_trace_bench.sv
module cof_trace_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 1'b0;
    logic        retire = 1'b0;
    logic [2:0]  iclass = 3'd0;
    logic [15:0] op_addr = '0;
    logic [15:0] dest_addr = '0;
    logic        taken = 1'b0;
    logic        rd_en = 1'b0;
    logic        fill_seen = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  fill;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cof_trace u_cof_trace (
        .clk(clk), .rst(rst), .arm(arm), .retire(retire), .iclass(iclass),
        .op_addr(op_addr), .dest_addr(dest_addr), .taken(taken),
        .rd_en(rd_en), .fill_seen(fill_seen), .rd_data(rd_data),
        .fill(fill), .overflow(overflow)
    );

    // {class[35:33], taken[32], op[31:16], dest[15:0]}
    localparam logic [35:0] VEC [12] = '{
        {3'd0, 1'b0, 16'h1000, 16'h2000},
        {3'd1, 1'b1, 16'h1010, 16'h1080},
        {3'd1, 1'b0, 16'h1020, 16'h1090},
        {3'd2, 1'b1, 16'h1030, 16'h10A0},
        {3'd3, 1'b0, 16'h1040, 16'h1041},
        {3'd4, 1'b1, 16'h1050, 16'h3000},
        {3'd5, 1'b0, 16'h1060, 16'h4000},
        {3'd6, 1'b0, 16'h1070, 16'hFFE0},
        {3'd7, 1'b1, 16'h1080, 16'h1234},
        {3'd0, 1'b1, 16'h1090, 16'h5555},
        {3'd5, 1'b1, 16'h10A0, 16'hABCD},
        {3'd1, 1'b1, 16'hFFFE, 16'h0002}
    };

    function automatic string req_of(input logic [2:0] c, input logic tk);
        case (c)
            3'd0, 3'd4: return "R1";
            3'd1:       return tk ? "R2" : "R3";
            3'd2, 3'd3: return "R4";
            3'd5:       return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic tk, input logic [15:0] op,
                        input logic [15:0] dst, input logic rt, input logic rd,
                        input logic seen);
        retire = rt; iclass = c; taken = tk; op_addr = op; dest_addr = dst;
        rd_en = rd; fill_seen = seen;
        @(negedge clk);
        retire = 1'b0; rd_en = 1'b0; fill_seen = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pop1();
        step(3'd0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk("R11", fill, 0);
        chk("R11", overflow, 0);
        arm = 1'b1;

        for (int i = 0; i < 12; i++) begin
            logic [2:0]  c;
            logic        tk, hit;
            logic [15:0] op, dst, expa;
            c = VEC[i][35:33]; tk = VEC[i][32];
            op = VEC[i][31:16]; dst = VEC[i][15:0];
            hit  = (c == 3'd1 && tk) || c >= 3'd5;
            expa = (c == 3'd1) ? op : dst;
            step(c, tk, op, dst, 1'b1, 1'b0, 1'b0);
            chk(req_of(c, tk), fill, hit ? 1 : 0);
            if (hit) begin
                chk(req_of(c, tk), rd_data, expa);
                pop1();
                chk("R7", fill, 0);
            end
        end

        // R7 order and R8 overwrite of oldest
        for (int i = 0; i < 8; i++)
            step(3'd6, 1'b0, 16'h0, 16'h0100 + 16'(i), 1'b1, 1'b0, 1'b0);
        chk("R7", fill, 8);
        chk("R8", overflow, 0);
        step(3'd7, 1'b0, 16'h0, 16'h0108, 1'b1, 1'b0, 1'b0);
        chk("R8", fill, 8);
        chk("R8", overflow, 1);
        for (int i = 1; i <= 8; i++) begin
            chk("R8", rd_data, 16'h0100 + 16'(i));
            pop1();
        end
        chk("R7", fill, 0);
        chk("R8", overflow, 1);

        // R9 clear
        step(3'd0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1);
        chk("R9", overflow, 0);

        // R12 pop on empty
        pop1();
        chk("R12", fill, 0);

        // R10 disarmed
        step(3'd5, 1'b0, 16'h0, 16'h7777, 1'b1, 1'b0, 1'b0);
        arm = 1'b0;
        step(3'd6, 1'b0, 16'h0, 16'h8888, 1'b1, 1'b0, 1'b0);
        step(3'd1, 1'b1, 16'h9999, 16'h0, 1'b1, 1'b0, 1'b0);
        chk("R10", fill, 1);
        chk("R10", rd_data, 16'h7777);
        arm = 1'b1;
        pop1();

        // R12 write plus read while full
        for (int i = 0; i < 8; i++)
            step(3'd6, 1'b0, 16'h0, 16'h0200 + 16'(i), 1'b1, 1'b0, 1'b0);
        step(3'd6, 1'b0, 16'h0, 16'h0208, 1'b1, 1'b1, 1'b0);
        chk("R12", fill, 8);
        chk("R12", overflow, 0);
        chk("R12", rd_data, 16'h0201);

        // R9 set wins over clear
        step(3'd6, 1'b0, 16'h0, 16'h0209, 1'b1, 1'b0, 1'b1);
        chk("R9", overflow, 1);
        chk("R8", rd_data, 16'h0202);

        // R11 reset from a busy state
        do_reset();
        chk("R11", fill, 0);
        chk("R11", overflow, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule